// File: doc/BRIEF.md
# Modulo-223 Fractional-N Divider Controller

This block steers the feedback divider of a fractional-N frequency synthesizer. It runs on the VCO-side clock and divides it down to a feedback pulse that goes to the phase comparator. Each division lasts either P or P+1 clock cycles. A fractional accumulator picks between the two. It steps by Q at the end of every division and wraps at 223. Over a full accumulator period the mean ratio is therefore P + Q/223. With a 557.5 kHz comparison rate, one unit of Q moves the output by 2.5 kHz.

The end of a division is the comparison-cycle boundary. It is also the only point where the block samples the programmed integer and fractional words. A caller can therefore rewrite either word at any time without shortening or stretching the division in progress. The block exposes three outputs: the feedback pulse, the modulus chosen for the division now running, and the accumulator value, which carries the phase residue.

Top module: `fracn_div_ctrl`

## Requirements
- R1: While reset is asserted (rst_ni low), fb_pulse_o, mod_sel_o and acc_o are all 0.
- R2: At each boundary, the 9-bit sum S = acc_o + Q is formed. If S >= 223, mod_sel_o becomes 1 and acc_o becomes S - 223. Otherwise mod_sel_o becomes 0 and acc_o becomes S.
- R3: fb_pulse_o is high for exactly one clock cycle per division. The number of clock cycles from one pulse to the next is P + mod_sel_o, where mod_sel_o is the value shown during the first of those two pulses.
- R4: Starting from reset with constant inputs, exactly Q of the first 223 divisions run with mod_sel_o = 1.
- R5: A div_frac_i value of 223 or more is used as 222.
- R6: A div_int_i value below 2 is used as 2.
- R7: div_int_i and div_frac_i are sampled only on the clock edge that raises fb_pulse_o. A change between two pulses does not alter the length of the division in progress, acc_o or mod_sel_o.
- R8: acc_o and mod_sel_o change only on the clock edge that raises fb_pulse_o, and acc_o is always below 223.
- R9: The first boundary happens on the first rising clock edge after reset is released. That edge raises fb_pulse_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | VCO-side clock being divided |
| rst_ni | input | 1 | Active-low synchronous reset |
| div_int_i | input | P_W (8) | Integer part P of the division ratio |
| div_frac_i | input | 8 | Fractional part Q, in units of 1/223 |
| fb_pulse_o | output | 1 | One-cycle feedback pulse, once per division |
| mod_sel_o | output | 1 | 1 while the division in progress is by P+1, 0 while it is by P |
| acc_o | output | 8 | Fractional accumulator residue, 0 to 222 |

## Verification
The assertions check on every cycle the properties that hold cycle by cycle:
- the accumulator stays below the modulus;
- accumulator and modulus select hold still between boundaries;
- the counter steps down by one between boundaries;
- the feedback pulse is one cycle wide;
- the modulus select agrees with the accumulator, which lands below the step just added exactly when a wrap occurred.

Only the bench's scenarios can show the rest:
- the exact sequence of residues and division lengths for a given P and Q;
- the count of long divisions over a full 223-division period;
- the clamping of out-of-range words;
- the deferral of a mid-division change to the next boundary.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

    // Modulus of the fractional accumulator and width of the fraction word.
    localparam int FRAC_MOD = 223;
    localparam int ACC_W    = 8;
    localparam int SUM_W    = ACC_W + 1;

    // Largest fraction accepted; larger requests are limited to this.
    localparam int FRAC_MAX = FRAC_MOD - 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             sel;
        logic [ACC_W-1:0] q_used;
    } acc_state_t;

endpackage

// File: rtl/fdc_word_cond.sv
module fdc_word_cond
    import fdc_pkg::*;
#(
    parameter int P_W   = 8,
    parameter int P_MIN = 2
) (
    input  logic [P_W-1:0]   p_raw_i,
    input  logic [ACC_W-1:0] q_raw_i,
    output logic [P_W-1:0]   p_eff_o,
    output logic [ACC_W-1:0] q_eff_o
);

    localparam logic [P_W-1:0]   P_FLOOR = P_W'(P_MIN);
    localparam logic [ACC_W-1:0] Q_CEIL  = ACC_W'(FRAC_MAX);

    // R6: integer part below the floor is raised to the floor.
    // R5: fraction at or above the modulus is limited to modulus-1.
    always_comb begin
        p_eff_o = (p_raw_i < P_FLOOR) ? P_FLOOR : p_raw_i;
        q_eff_o = (q_raw_i > Q_CEIL)  ? Q_CEIL  : q_raw_i;
    end

endmodule

// File: rtl/fdc_frac_acc.sv
module fdc_frac_acc
    import fdc_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic [ACC_W-1:0] q_eff_i,
    output logic             carry_next_o,
    output logic [ACC_W-1:0] acc_o,
    output logic             sel_o
);

    localparam logic [SUM_W-1:0] MOD_S = SUM_W'(FRAC_MOD);

    acc_state_t       st_q;
    acc_state_t       st_d;
    logic [SUM_W-1:0] sum;
    logic             wrap;

    // Nine-bit add and compare; the wrap removes one modulus.
    always_comb begin
        sum  = {1'b0, st_q.acc} + {1'b0, q_eff_i};
        wrap = (sum >= MOD_S);
        st_d = st_q;
        if (step_i) begin
            st_d.sel    = wrap;
            st_d.q_used = q_eff_i;
            if (wrap) begin
                st_d.acc = ACC_W'(sum - MOD_S);
            end else begin
                st_d.acc = sum[ACC_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign carry_next_o = wrap;
    assign acc_o        = st_q.acc;
    assign sel_o        = st_q.sel;

    // R8: residue never reaches the modulus.
    a_r8_acc_below_mod: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.acc < ACC_W'(FRAC_MOD));

    // R8: no movement between boundaries.
    a_r8_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !step_i |=> ($stable(st_q.acc) && $stable(st_q.sel)));

    // R2: after a step the new residue is below the step added exactly when a wrap occurred.
    a_r2_wrap_consistent: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_i |=> (st_q.sel == (st_q.acc < st_q.q_used)));

endmodule

// File: rtl/fdc_mod_counter.sv
module fdc_mod_counter #(
    parameter int P_W = 8
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [P_W-1:0] p_eff_i,
    input  logic           sel_next_i,
    output logic           tc_o,
    output logic           fb_o
);

    localparam int L_W = P_W + 1;

    typedef struct packed {
        logic [P_W-1:0] cnt;
        logic           fb;
    } cnt_state_t;

    cnt_state_t     st_q;
    cnt_state_t     st_d;
    logic [L_W-1:0] load;
    logic           tc;

    // A division of length N loads N-1 and runs down to zero.
    always_comb begin
        tc   = (st_q.cnt == '0);
        load = {1'b0, p_eff_i} + L_W'(sel_next_i) - L_W'(1);
        st_d.fb = tc;
        if (tc) begin
            st_d.cnt = load[P_W-1:0];
        end else begin
            st_d.cnt = st_q.cnt - P_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tc_o = tc;
    assign fb_o = st_q.fb;

    // R3: between boundaries the count only steps down by one.
    a_r3_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - P_W'(1)));

    // R3: the feedback pulse is a single cycle (length is at least two).
    a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.fb |=> !st_q.fb);

endmodule

// File: rtl/fracn_div_ctrl.sv
module fracn_div_ctrl
    import fdc_pkg::*;
#(
    parameter int P_W   = 8,
    parameter int P_MIN = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [P_W-1:0]   div_int_i,
    input  logic [ACC_W-1:0] div_frac_i,
    output logic             fb_pulse_o,
    output logic             mod_sel_o,
    output logic [ACC_W-1:0] acc_o
);

    logic [P_W-1:0]   p_eff;
    logic [ACC_W-1:0] q_eff;
    logic             tc;
    logic             carry_next;

    fdc_word_cond #(
        .P_W   (P_W),
        .P_MIN (P_MIN)
    ) u_cond (
        .p_raw_i (div_int_i),
        .q_raw_i (div_frac_i),
        .p_eff_o (p_eff),
        .q_eff_o (q_eff)
    );

    fdc_frac_acc u_acc (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .step_i       (tc),
        .q_eff_i      (q_eff),
        .carry_next_o (carry_next),
        .acc_o        (acc_o),
        .sel_o        (mod_sel_o)
    );

    fdc_mod_counter #(
        .P_W (P_W)
    ) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .p_eff_i    (p_eff),
        .sel_next_i (carry_next),
        .tc_o       (tc),
        .fb_o       (fb_pulse_o)
    );

    // R9/R7: select and residue move together with the pulse edge.
    a_r7_update_on_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fb_pulse_o |-> ($stable(mod_sel_o) && $stable(acc_o)));

endmodule

// File: tb/tb_fracn_div_ctrl.sv
`timescale 1ns/1ps
module tb_fracn_div_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] p_in = 8'd10;
    logic [7:0] q_in = 8'd0;
    logic       fb;
    logic       sel;
    logic [7:0] acc;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    fracn_div_ctrl dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .div_int_i  (p_in),
        .div_frac_i (q_in),
        .fb_pulse_o (fb),
        .mod_sel_o  (sel),
        .acc_o      (acc)
    );

    // Stimulus table: raw P, raw Q.
    localparam int NV = 9;
    localparam logic [7:0] VP [NV] = '{8'd10, 8'd10, 8'd10, 8'd10, 8'd7, 8'd12, 8'd2, 8'd1, 8'd0};
    localparam logic [7:0] VQ [NV] = '{8'd0, 8'd1, 8'd111, 8'd222, 8'd223, 8'd255, 8'd50, 8'd100, 8'd5};

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Count negedge samples until fb is seen high.
    task automatic wait_fb(output int n);
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (fb) break;
            if (n > 2000) begin
                chk(1'b0, "R3 timeout waiting for pulse", n, 0);
                break;
            end
        end
    endtask

    task automatic do_reset(input logic [7:0] p, input logic [7:0] q);
        @(negedge clk);
        rst_n = 1'b0;
        p_in  = p;
        q_in  = q;
        repeat (3) @(negedge clk);
        chk(fb == 1'b0, "R1 fb in reset", int'(fb), 0);
        chk(sel == 1'b0, "R1 sel in reset", int'(sel), 0);
        chk(acc == 8'd0, "R1 acc in reset", int'(acc), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        int n;
        int pe;
        int qe;
        int macc;
        int msel;
        int prev_len;
        int longs;
        int s;

        for (int v = 0; v < NV; v++) begin
            pe = (VP[v] < 8'd2) ? 2 : int'(VP[v]);      // R6
            qe = (VQ[v] > 8'd222) ? 222 : int'(VQ[v]);  // R5
            do_reset(VP[v], VQ[v]);
            macc = 0;
            longs = 0;
            prev_len = 0;
            for (int k = 0; k <= 223; k++) begin
                wait_fb(n);
                if (k == 0) chk(n == 1, "R9 first pulse after reset", n, 1);
                else        chk(n == prev_len, "R3 division length", n, prev_len);
                if (k == 223) break;
                s = macc + qe;
                msel = (s >= 223) ? 1 : 0;
                macc = msel ? s - 223 : s;
                chk(int'(acc) == macc, "R2 accumulator", int'(acc), macc);
                chk(int'(sel) == msel, "R2 modulus select", int'(sel), msel);
                longs += msel;
                prev_len = pe + msel;
            end
            chk(longs == qe, "R4 long divisions per period (R5 clamp)", longs, qe);
        end

        // R7/R8: change words mid-division; effect deferred to next boundary.
        do_reset(8'd10, 8'd0);
        wait_fb(n);
        chk(n == 1, "R9 first pulse", n, 1);
        repeat (3) @(negedge clk);
        p_in = 8'd6;
        q_in = 8'd100;
        @(negedge clk);
        chk(acc == 8'd0, "R7 acc unchanged mid-division", int'(acc), 0);
        chk(sel == 1'b0, "R8 sel unchanged mid-division", int'(sel), 0);
        wait_fb(n);
        chk(n == 6, "R7 current division keeps old length", n + 4, 10);
        chk(acc == 8'd100, "R7 new Q at boundary", int'(acc), 100);
        wait_fb(n);
        chk(n == 6, "R7 new P used", n, 6);
        chk(acc == 8'd200, "R2 second step", int'(acc), 200);
        wait_fb(n);
        chk(n == 6, "R3 length P", n, 6);
        chk(acc == 8'd77, "R2 wrap residue", int'(acc), 77);
        chk(sel == 1'b1, "R2 wrap select", int'(sel), 1);
        @(negedge clk);
        chk(fb == 1'b0, "R3 pulse one cycle wide", int'(fb), 0);
        chk(acc == 8'd77, "R8 acc holds after pulse", int'(acc), 77);
        wait_fb(n);
        chk(n == 6, "R3 length P+1", n + 1, 7);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule